// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core services next. It takes five single-cycle request pulses from peripherals and one reset request. For each peripheral source it keeps a pending flag and an enable bit. It also holds one global interrupt enable. When the core reports an instruction boundary, the block picks the eligible request with the lowest vector number. It then raises a one-cycle accept strobe together with that vector's word address.

On acceptance the hardware drops the global enable, so every further interrupt is masked. It also clears the pending flag of the accepted source. A return strobe from the core turns the global enable back on. A handler may also turn it on itself through the register port, and a pending request can then be taken inside that handler (nesting).

The reset request cannot be masked. It wipes all flags, all enables and the global enable. At the next boundary it is taken at vector 0, whatever the enable state. Software reads the flags, enables and global enable through a small register port. The flags are cleared by writing ones to them.

Top module: `prio_vec_intc`

## Requirements
- R1: Vector 0 is the reset request. Request bit `irq_i[k]` maps to vector k+1: bit 0 is external request 0, bit 1 is external request 1, bit 2 is port low-level input, bit 3 is timer 0 overflow and bit 4 is the analog comparator.
- R2: When several requests are eligible, the lowest vector number is the one accepted.
- R3: A source is accepted only when its pending flag, its enable bit and the global enable are all 1. A pending flag whose enable is 0 stays set, and it is accepted at a later boundary once its enable is written to 1.
- R4: Accepting a peripheral request clears the global enable and clears that source's pending flag at the same clock edge. All other flags are untouched.
- R5: Writing the flag register (address 0) clears each flag whose data bit is 1, and a 0 bit has no effect. A request pulse in the same cycle as a clear of that flag leaves the flag set.
- R6: A cycle with `reti_i` high sets the global enable to 1, unless the same cycle accepts an interrupt, writes the control register or carries a reset request.
- R7: Software may write the global enable to 1 inside a handler (address 2, bit 0). A pending, enabled request is then accepted at the next boundary.
- R8: A reset request clears all flags, all enables and the global enable at the next edge. It is then accepted at vector 0 at the next boundary, regardless of any enable, and it is accepted only once.
- R9: `take_o` is high only in a cycle with `boundary_i` high and an eligible request. `vec_o` is 0 whenever `take_o` is low. Holding `boundary_i` high for two cycles yields a single acceptance.
- R10: Address 1 holds the enable bits in bits 4:0 and address 2 holds the global enable in bit 0. Reads are combinational and unused bits read 0. After `rst_ni` every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 5 | Peripheral request pulses, bit k is vector k+1 |
| rst_req_i | input | 1 | Reset request pulse (vector 0) |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address: 0 flags, 1 enables, 2 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| take_o | output | 1 | Accept strobe, one cycle |
| vec_o | output | 3 | Accepted vector word address |

## Verification
The bench builds the block with its defaults: five sources, an 8-bit data path and a 3-bit vector. With these values every vector from 0 to 5 can be reached, along with every priority pairing among the five flags. Each flag register bit can be cleared individually. The same cycle can carry a request pulse and a software clear, and the reset request can be tested against fully enabled state. Nesting is exercised by re-enabling inside a handler while a higher-priority request is pending.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    REG_FLAG = 2'd0,
    REG_EN   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_GIE_BIT = 0;
endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[k] <= 1'b0;
      else if (clr_all_i) flag_o[k] <= 1'b0;
      // a new request beats both clear paths
      else if (set_i[k])  flag_o[k] <= 1'b1;
      else if (w1c_i[k] || ack_i[k]) flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N  = 5,
  parameter int VW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  grant_o
);
  // lowest index wins; vector = index + 1 (vector 0 is reset)
  always_comb begin
    any_o   = 1'b0;
    vec_o   = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o      = 1'b1;
        vec_o      = VW'(i + 1);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int N      = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  input  logic              reti_i,
  input  logic [N-1:0]      flag_i,
  output logic [N-1:0]      en_o,
  output logic              gie_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;
  logic     wr_en, wr_ctrl;

  assign sel     = reg_sel_e'(addr_i[1:0]);
  assign wr_en   = wr_i && (sel == REG_EN);
  assign wr_ctrl = wr_i && (sel == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_o <= '0;
    else if (clr_all_i) en_o <= '0;
    else if (wr_en)     en_o <= wdata_i[N-1:0];
  end

  // order: reset request, acceptance, software write, return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gie_o <= 1'b0;
    else if (clr_all_i) gie_o <= 1'b0;
    else if (take_i)    gie_o <= 1'b0;
    else if (wr_ctrl)   gie_o <= wdata_i[CTRL_GIE_BIT];
    else if (reti_i)    gie_o <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_FLAG: rdata_o = DATA_W'(flag_i);
      REG_EN:   rdata_o = DATA_W'(en_o);
      REG_CTRL: rdata_o[CTRL_GIE_BIT] = gie_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  localparam int VEC_W  = $clog2(NUM_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic              rst_req_i,
  input  logic              boundary_i,
  input  logic              reti_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NUM_SRC-1:0] flag_q, en_q, elig, grant, ack, w1c;
  logic               gie_q, irq_any, rst_pend_q;
  logic [VEC_W-1:0]   irq_vec;

  assign w1c = (reg_wr_i && reg_sel_e'(reg_addr_i[1:0]) == REG_FLAG)
             ? reg_wdata_i[NUM_SRC-1:0] : '0;

  intc_flags #(.N(NUM_SRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (rst_req_i),
    .set_i     (irq_i),
    .w1c_i     (w1c),
    .ack_i     (ack),
    .flag_o    (flag_q)
  );

  intc_cfg #(.N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (rst_req_i),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .take_i    (take_o),
    .reti_i    (reti_i),
    .flag_i    (flag_q),
    .en_o      (en_q),
    .gie_o     (gie_q),
    .rdata_o   (reg_rdata_o)
  );

  assign elig = flag_q & en_q & {NUM_SRC{gie_q}};

  intc_arbiter #(.N(NUM_SRC), .VW(VEC_W)) u_arb (
    .req_i   (elig),
    .any_o   (irq_any),
    .vec_o   (irq_vec),
    .grant_o (grant)
  );

  // reset request is latched and ignores every enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rst_pend_q <= 1'b0;
    else if (rst_req_i)  rst_pend_q <= 1'b1;
    else if (boundary_i) rst_pend_q <= 1'b0;
  end

  assign take_o = boundary_i && (rst_pend_q || irq_any);
  assign vec_o  = (take_o && !rst_pend_q) ? irq_vec : '0;
  assign ack    = (boundary_i && !rst_pend_q) ? grant : '0;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 5,
  parameter int VEC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               rst_req_i,
  input logic               boundary_i,
  input logic               reti_i,
  input logic               reg_wr_i,
  input logic               take_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               gie_q
);
  // R9
  take_needs_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> boundary_i);

  // R9
  vec_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (vec_o == '0));

  // R3
  periph_take_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o != '0) |-> (gie_q && ((flag_q & en_q) != '0)));

  // R4
  take_masks_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !gie_q);

  // R6
  reti_sets_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_o && !reg_wr_i && !rst_req_i) |=> gie_q);

  // R5
  request_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_i && irq_i != '0) |=> ((flag_q & $past(irq_i)) == $past(irq_i)));

  // R8
  reset_req_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (flag_q == '0 && en_q == '0 && !gie_q));
endmodule

bind prio_vec_intc intc_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .rst_req_i  (rst_req_i),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .reg_wr_i   (reg_wr_i),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .gie_q      (gie_q)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] irq_i = '0;
  logic       rst_req_i = 1'b0;
  logic       boundary_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       take_o;
  logic [2:0] vec_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  prio_vec_intc u_prio_vec_intc (.*);

  // {irq[13:9], en[8:4], take[3], vec[2:0]}
  localparam logic [13:0] VEC_TBL [12] = '{
    {5'b00001, 5'b11111, 1'b1, 3'd1},
    {5'b00010, 5'b11111, 1'b1, 3'd2},
    {5'b00100, 5'b11111, 1'b1, 3'd3},
    {5'b01000, 5'b11111, 1'b1, 3'd4},
    {5'b10000, 5'b11111, 1'b1, 3'd5},
    {5'b11111, 5'b11111, 1'b1, 3'd1},
    {5'b11110, 5'b11111, 1'b1, 3'd2},
    {5'b10100, 5'b11111, 1'b1, 3'd3},
    {5'b11000, 5'b10111, 1'b1, 3'd5},
    {5'b00110, 5'b11001, 1'b0, 3'd0},
    {5'b00000, 5'b11111, 1'b0, 3'd0},
    {5'b11100, 5'b01000, 1'b1, 3'd4}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk_i);
    irq_i = m;
    @(negedge clk_i);
    irq_i = '0;
  endtask

  task automatic bnd(output logic t, output logic [2:0] v);
    @(negedge clk_i);
    boundary_i = 1'b1;
    #1 t = take_o; v = vec_o;
    @(negedge clk_i);
    boundary_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       t;
    logic [2:0] v;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    rd(2'd0, d); chk("R10 flags after reset", d, 8'h00);
    rd(2'd1, d); chk("R10 enables after reset", d, 8'h00);
    rd(2'd2, d); chk("R10 gie after reset", d, 8'h00);
    bnd(t, v);   chk("R9 no take after reset", {7'b0, t}, 8'h00);

    // R1 R2 R3 R4 table
    for (int i = 0; i < 12; i++) begin
      logic [13:0] e;
      e = VEC_TBL[i];
      wr(2'd1, {3'b0, e[8:4]});
      pulse(e[13:9]);
      wr(2'd2, 8'h01);
      bnd(t, v);
      chk("R1 R2 R3 take", {7'b0, t}, {7'b0, e[3]});
      chk("R1 R2 vector", {5'b0, v}, {5'b0, e[2:0]});
      rd(2'd2, d);
      chk("R4 gie after boundary", d, e[3] ? 8'h00 : 8'h01);
      if (e[3]) begin
        rd(2'd0, d);
        chk("R4 taken flag cleared", {3'b0, d[4:0]},
            {3'b0, e[13:9] & ~(5'b1 << (e[2:0] - 3'd1))});
      end
      wr(2'd0, 8'h1F);
      wr(2'd2, 8'h00);
    end

    // R3 disabled pending flag taken later
    wr(2'd1, 8'h00);
    pulse(5'b00100);
    wr(2'd2, 8'h01);
    bnd(t, v);   chk("R3 masked by enable", {7'b0, t}, 8'h00);
    rd(2'd0, d); chk("R3 flag stays pending", d, 8'h04);
    wr(2'd1, 8'h04);
    bnd(t, v);   chk("R3 taken once enabled", {5'b0, v}, 8'h03);
    rd(2'd1, d); chk("R10 enable readback", d, 8'h04);

    // R9 no boundary, then boundary held two cycles
    wr(2'd1, 8'h1F);
    pulse(5'b00011);
    wr(2'd2, 8'h01);
    @(negedge clk_i); #1;
    chk("R9 no take without boundary", {7'b0, take_o}, 8'h00);
    chk("R9 vec zero when idle", {5'b0, vec_o}, 8'h00);
    @(negedge clk_i);
    boundary_i = 1'b1;
    #1 chk("R9 first boundary cycle", {take_o, 4'b0, vec_o}, 8'h81);
    @(negedge clk_i); #1;
    chk("R9 second boundary cycle", {7'b0, take_o}, 8'h00);
    boundary_i = 1'b0;

    // R6 return restores gie, then pending bit1 is taken
    @(negedge clk_i);
    reti_i = 1'b1;
    @(negedge clk_i);
    reti_i = 1'b0;
    rd(2'd2, d); chk("R6 reti sets gie", d, 8'h01);
    bnd(t, v);   chk("R6 pending taken after return", {5'b0, v}, 8'h02);

    // R5 write-1-to-clear
    pulse(5'b11111);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R5 zero write no effect", d, 8'h1F);
    wr(2'd0, 8'h05);
    rd(2'd0, d); chk("R5 clear bits 0 and 2", d, 8'h1A);
    @(negedge clk_i);
    irq_i = 5'b01000; reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h18;
    @(negedge clk_i);
    irq_i = '0; reg_wr_i = 1'b0;
    rd(2'd0, d); chk("R5 request beats clear", d, 8'h0A);
    wr(2'd0, 8'h1F);

    // R7 nesting
    wr(2'd1, 8'h1F);
    pulse(5'b10100);
    wr(2'd2, 8'h01);
    bnd(t, v);   chk("R7 outer handler vector", {5'b0, v}, 8'h03);
    pulse(5'b00001);
    bnd(t, v);   chk("R7 masked inside handler", {7'b0, t}, 8'h00);
    wr(2'd2, 8'h01);
    bnd(t, v);   chk("R7 nested higher request", {t, 4'b0, v}, 8'h81);
    rd(2'd0, d); chk("R7 lower request still pending", d, 8'h10);

    // R8 reset request
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h00);
    pulse(5'b00110);
    @(negedge clk_i);
    rst_req_i = 1'b1;
    @(negedge clk_i);
    rst_req_i = 1'b0;
    rd(2'd0, d); chk("R8 flags cleared", d, 8'h00);
    rd(2'd1, d); chk("R8 enables cleared", d, 8'h00);
    rd(2'd2, d); chk("R8 gie cleared", d, 8'h00);
    bnd(t, v);   chk("R8 unmaskable vector 0", {t, 4'b0, v}, 8'h80);
    bnd(t, v);   chk("R8 taken only once", {7'b0, t}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule